// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

This block is the combinational integer execution unit of a small load/store RISC core. Each cycle the decode stage supplies a five-bit operation code, two operands, and a five-bit constant shift count taken from the instruction. The unit returns a result that is the full operand width and a trap flag that goes high on signed overflow. It also returns a zero flag, which the branch logic uses for equality tests by subtracting one operand from the other.

The decode stage has already sign- or zero-extended any immediate before it reaches operand `b_i`. The unit does not read or write registers, does not handle exceptions, and has no multiplier or divider. Overflow is reported only for the two trapping signed operations. The non-trapping add and subtract codes give the same wrapped sum or difference without raising the flag.

Shifts always act on operand `b_i`. For the constant forms the count comes from `shamt_i`. For the variable forms the count is the low five bits of operand `a_i`, and the upper bits of `a_i` are ignored. The signed and unsigned set-less-than operations use the same subtractor as the arithmetic operations.

Top module: `alu_core`

## Requirements
- R1: Codes 0 (trapping add) and 1 (non-trapping add) give a+b mod 2^32. Codes 2 (trapping subtract) and 3 (non-trapping subtract) give a-b mod 2^32.
- R2: `ovf_o` is 1 for code 0 exactly when both operands have the same sign and the sign of the sum differs from it. For code 2 it is 1 exactly when the operand signs differ and the sign of the difference differs from the sign of a.
- R3: `ovf_o` is 0 for every code other than 0 and 2, including codes 1 and 3 when their operands would overflow as signed numbers.
- R4: Code 4 gives a AND b, code 5 gives a OR b, code 6 gives a XOR b, and code 7 gives NOT(a OR b), over all 32 bits.
- R5: Code 8 gives 1 when a < b as two's-complement numbers and 0 otherwise. Bits 31:1 of the result are always 0. For a=0xFFFFFFFF and b=1 it gives 1.
- R6: Code 9 gives 1 when a < b as unsigned numbers and 0 otherwise. For a=0xFFFFFFFF and b=1 it gives 0.
- R7: Codes 10, 11 and 12 shift b by `shamt_i` (0 to 31). Code 10 shifts left and fills with zeros. Code 11 shifts right and fills with zeros. Code 12 shifts right and fills with bit 31 of b.
- R8: Codes 13, 14 and 15 perform the same left, logical-right and arithmetic-right shifts of b, but the count is a[4:0]. Bits 31:5 of a and the value of `shamt_i` have no effect.
- R9: Code 16 gives {b[15:0], 16'h0000}.
- R10: `zero_o` is 1 exactly when the 32-bit result is zero.
- R11: Codes 17 to 31 give a result of 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | 32 | First operand; its low bits are the count for variable shifts |
| b_i | input | 32 | Second operand, already extended; the data input for shifts and upper-immediate loads |
| shamt_i | input | 5 | Constant shift count from the instruction |
| result_o | output | 32 | Result of the operation |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds the unit with its default 32-bit width, so the 5-bit count covers every shift from 0 to 31. With this width the corner cases come from bit 31: the most negative value, carries out of bit 31, and the two halves used by the upper-immediate load. Shift counts of 0 and 31 are tested, along with overflow at both ends of the signed range. Variable-shift operands have non-zero upper bits so that the bench can see they are ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_SLL  = 5'd10,
        OP_SRL  = 5'd11,
        OP_SRA  = 5'd12,
        OP_SLLV = 5'd13,
        OP_SRLV = 5'd14,
        OP_SRAV = 5'd15,
        OP_LUI  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT    = 2'd0,
        SH_LOGIC_R = 2'd1,
        SH_ARITH_R = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             sgn_ovf,
    output logic             lt_signed,
    output logic             lt_unsigned
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff       = sub ? ~b : b;
        full        = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum         = full[MSB:0];
        sgn_ovf     = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_signed   = sum[MSB] ^ sgn_ovf;
        lt_unsigned = sub & ~full[WIDTH];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [SHW-1:0]   amt,
    input  shift_kind_e      kind,
    output logic [WIDTH-1:0] y
);
    localparam int MSB = WIDTH - 1;

    logic             left;
    logic             fill;
    logic [WIDTH-1:0] stage [SHW+1];
    logic [WIDTH-1:0] last;

    assign left = (kind == SH_LEFT);
    assign fill = (kind == SH_ARITH_R) & data[MSB];

    // A left shift is a right shift of the bit-reversed word.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            stage[0][i] = left ? data[MSB-i] : data[i];
        end
    end

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][MSB:STEP]} : stage[s];
    end

    assign last = stage[SHW];

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            y[i] = left ? last[MSB-i] : last[i];
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]          op_i,
    input  logic [WIDTH-1:0]         a_i,
    input  logic [WIDTH-1:0]         b_i,
    input  logic [$clog2(WIDTH)-1:0] shamt_i,
    output logic [WIDTH-1:0]         result_o,
    output logic                     ovf_o,
    output logic                     zero_o
);
    localparam int SHW  = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    alu_op_e          op;
    logic             use_sub;
    logic_sel_e       lg_sel;
    shift_kind_e      sh_kind;
    logic             sh_var;
    logic [SHW-1:0]   sh_amt;
    logic [WIDTH-1:0] sum, lg_y, sh_y;
    logic             sgn_ovf, lt_s, lt_u;

    assign op = alu_op_e'(op_i);

    always_comb begin
        use_sub = 1'b0;
        lg_sel  = LG_AND;
        sh_kind = SH_LEFT;
        sh_var  = 1'b0;
        unique case (op)
            OP_SUB, OP_SUBU, OP_SLT, OP_SLTU: use_sub = 1'b1;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            OP_NOR:  lg_sel = LG_NOR;
            OP_SRL:  sh_kind = SH_LOGIC_R;
            OP_SRA:  sh_kind = SH_ARITH_R;
            OP_SLLV: sh_var = 1'b1;
            OP_SRLV: begin sh_kind = SH_LOGIC_R; sh_var = 1'b1; end
            OP_SRAV: begin sh_kind = SH_ARITH_R; sh_var = 1'b1; end
            default: ;
        endcase
    end

    assign sh_amt = sh_var ? a_i[SHW-1:0] : shamt_i;

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(a_i), .b(b_i), .sub(use_sub),
        .sum(sum), .sgn_ovf(sgn_ovf), .lt_signed(lt_s), .lt_unsigned(lt_u)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a(a_i), .b(b_i), .sel(lg_sel), .y(lg_y)
    );

    alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .data(b_i), .amt(sh_amt), .kind(sh_kind), .y(sh_y)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = lg_y;
            OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, lt_s};
            OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result_o = sh_y;
            OP_LUI:  result_o = {b_i[HALF-1:0], {(WIDTH-HALF){1'b0}}};
            default: result_o = '0;
        endcase
    end

    assign ovf_o  = ((op == OP_ADD) || (op == OP_SUB)) && sgn_ovf;
    assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] result_o,
    input logic             ovf_o,
    input logic             zero_o
);
    localparam int MSB  = WIDTH - 1;
    localparam int HALF = WIDTH / 2;

    always_comb begin
        if (op_i != OP_ADD && op_i != OP_SUB && ovf_o !== 1'bx) begin
            p_no_overflow_r3: assert (!ovf_o);
        end
        if (op_i == OP_ADD && ovf_o === 1'b1) begin
            p_add_ovf_sign_r2: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]);
        end
        if (op_i == OP_SUB && ovf_o === 1'b1) begin
            p_sub_ovf_sign_r2: assert (a_i[MSB] != b_i[MSB] && result_o[MSB] != a_i[MSB]);
        end
        if (op_i == OP_SLT || op_i == OP_SLTU) begin
            p_slt_narrow_r5: assert (result_o[MSB:1] == '0);
        end
        if (op_i == OP_SRA && b_i[MSB] === 1'b1) begin
            p_sra_sign_fill_r7: assert (result_o[MSB]);
        end
        if (op_i == OP_LUI) begin
            p_lui_low_clear_r9: assert (result_o[HALF-1:0] == '0);
        end
        if (op_i == OP_SUBU && a_i == b_i && zero_o !== 1'bx) begin
            p_equal_zero_r10: assert (zero_o);
        end
        if (op_i > OP_LUI && op_i !== 'x) begin
            p_undef_quiet_r11: assert (result_o == '0 && !ovf_o);
        end
    end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic [4:0]    op;
    logic [W-1:0]  a, b;
    logic [4:0]    sh;
    logic [W-1:0]  res;
    logic          ovf, zero;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    alu_core #(.WIDTH(W)) dut (
        .op_i(op), .a_i(a), .b_i(b), .shamt_i(sh),
        .result_o(res), .ovf_o(ovf), .zero_o(zero)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements): got %0d cycles, expected fewer than 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected values derived from the requirement text.
    task automatic run(input string req, input logic [4:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [4:0] s);
        logic [W-1:0] e;
        logic         eo;
        longint       wide;
        eo = 1'b0;
        case (o)
            5'd0, 5'd1: e = x + y;
            5'd2, 5'd3: e = x - y;
            5'd4:  e = x & y;
            5'd5:  e = x | y;
            5'd6:  e = x ^ y;
            5'd7:  e = ~(x | y);
            5'd8:  e = ($signed(x) < $signed(y)) ? 1 : 0;
            5'd9:  e = (x < y) ? 1 : 0;
            5'd10: e = y << s;
            5'd11: e = y >> s;
            5'd12: e = $signed(y) >>> s;
            5'd13: e = y << x[4:0];
            5'd14: e = y >> x[4:0];
            5'd15: e = $signed(y) >>> x[4:0];
            5'd16: e = {y[15:0], 16'h0000};
            default: e = '0;
        endcase
        if (o == 5'd0 || o == 5'd2) begin
            wide = (o == 5'd0) ? longint'($signed(x)) + longint'($signed(y))
                               : longint'($signed(x)) - longint'($signed(y));
            eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        end
        op = o; a = x; b = y; sh = s;
        @(negedge clk);
        chk(req, $sformatf("result op=%0d", o), res, e);
        chk(req, $sformatf("ovf op=%0d", o), {31'b0, ovf}, {31'b0, eo});
        chk("R10", $sformatf("zero op=%0d", o), {31'b0, zero}, {31'b0, (e == '0)});
    endtask

    task automatic t_reset_state();
        run("R1", 5'd0, '0, '0, 5'd0);
    endtask

    task automatic t_add_sub_r1();
        run("R1", 5'd0, 32'd100, 32'hFFFF_FFCE, 5'd0);
        run("R1", 5'd1, 32'hFFFF_FFFF, 32'd1, 5'd0);
        run("R1", 5'd2, 32'd5, 32'd9, 5'd0);
        run("R1", 5'd3, 32'h1234_5678, 32'h1234_5678, 5'd0);
    endtask

    task automatic t_overflow_r2();
        run("R2", 5'd0, 32'h7FFF_FFFF, 32'd1, 5'd0);
        run("R2", 5'd0, 32'h8000_0000, 32'h8000_0000, 5'd0);
        run("R2", 5'd0, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        run("R2", 5'd2, 32'h8000_0000, 32'd1, 5'd0);
        run("R2", 5'd2, 32'd0, 32'h8000_0000, 5'd0);
        run("R2", 5'd2, 32'hFFFF_FFFF, 32'h8000_0000, 5'd0);
    endtask

    task automatic t_no_overflow_r3();
        run("R3", 5'd1, 32'h7FFF_FFFF, 32'd1, 5'd0);
        run("R3", 5'd3, 32'h8000_0000, 32'd1, 5'd0);
        run("R3", 5'd10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd1);
        run("R3", 5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
    endtask

    task automatic t_logic_r4();
        for (int k = 4; k <= 7; k++) begin
            run("R4", 5'(k), 32'hF0F0_A5A5, 32'hFF00_5AA5, 5'd0);
            run("R4", 5'(k), 32'h0000_0000, 32'h0000_0000, 5'd0);
        end
    endtask

    task automatic t_compare_r5_r6();
        run("R5", 5'd8, 32'hFFFF_FFFF, 32'd1, 5'd0);
        run("R6", 5'd9, 32'hFFFF_FFFF, 32'd1, 5'd0);
        run("R5", 5'd8, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        run("R6", 5'd9, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        run("R5", 5'd8, 32'd7, 32'd7, 5'd0);
        run("R6", 5'd9, 32'd2, 32'd3, 5'd0);
    endtask

    task automatic t_shift_const_r7();
        run("R7", 5'd10, 32'hFFFF_FFFF, 32'h8000_0001, 5'd0);
        run("R7", 5'd10, 32'h0, 32'h8000_0001, 5'd31);
        run("R7", 5'd11, 32'h0, 32'h8000_0000, 5'd31);
        run("R7", 5'd12, 32'h0, 32'h8000_0000, 5'd31);
        run("R7", 5'd12, 32'h0, 32'h8765_4321, 5'd4);
        run("R7", 5'd12, 32'h0, 32'h4765_4321, 5'd4);
        run("R7", 5'd11, 32'h0, 32'h8765_4321, 5'd13);
    endtask

    task automatic t_shift_var_r8();
        run("R8", 5'd13, 32'hFFFF_FFE3, 32'h0000_00FF, 5'd7);
        run("R8", 5'd14, 32'hABCD_EF1F, 32'hF000_0000, 5'd2);
        run("R8", 5'd15, 32'h1234_5668, 32'h8000_1234, 5'd0);
        run("R8", 5'd15, 32'h0000_0020, 32'h8000_1234, 5'd9);
    endtask

    task automatic t_lui_r9();
        run("R9", 5'd16, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5'd0);
        run("R9", 5'd16, 32'h0, 32'h0000_8001, 5'd0);
    endtask

    task automatic t_zero_r10();
        run("R10", 5'd1, 32'hFFFF_FFFF, 32'd1, 5'd0);
        run("R10", 5'd4, 32'hAAAA_AAAA, 32'h5555_5555, 5'd0);
        run("R10", 5'd2, 32'd3, 32'd2, 5'd0);
    endtask

    task automatic t_undef_r11();
        run("R11", 5'd17, 32'h7FFF_FFFF, 32'd1, 5'd3);
        run("R11", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
    endtask

    initial begin
        op = '0; a = '0; b = '0; sh = '0;
        @(negedge clk);
        t_reset_state();
        t_add_sub_r1();
        t_overflow_r2();
        t_no_overflow_r3();
        t_logic_r4();
        t_compare_r5_r6();
        t_shift_const_r7();
        t_shift_var_r8();
        t_lui_r9();
        t_zero_r10();
        t_undef_r11();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule